// File: doc/BRIEF.md
# Two-Thread Congestion Throttle with Weighted Decode Sharing

This block sits beside the front end of a core that runs two hardware threads. It watches two congestion signs for each thread: how many L2 load misses and TLB misses the thread has outstanding, and how many reorder-buffer entries it holds. When either sign passes its programmed limit for long enough, the block raises the thread's throttle one step at a time. The first step lowers the thread's weight in decode sharing. The second step blocks its decode. The third step also asks for a flush of the thread's instructions that are waiting to dispatch.

Decode cycles are handed out over a 16-cycle frame. Each thread's share of the frame is proportional to its software priority after throttling. The slots are spread evenly through the frame rather than given in bursts. When a thread is blocked, any slot that would have gone to it is given to the other thread. The two threads are never blocked at the same time.

The decode and flush machinery and the sources of the miss and fill pulses lie outside the block.

Top module: `smt_throttle_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every output is 0. No decode grant is given during the first frame of 16 cycles after release.
- R2: Each thread keeps a count of outstanding misses. Every L2-miss or TLB-miss pulse adds 1 and every L2-fill or TLB-fill pulse subtracts 1, all summed in the same cycle. The count saturates at 0 and at its maximum. A count that is at or above the miss threshold triggers the thread.
- R3: A thread is also triggered, in the same cycle, when its reorder-buffer occupancy is at or above the occupancy limit. At limit minus 1 it is not triggered.
- R4: The levels are 0 normal, 1 lowered, 2 blocked and 3 flush. A thread whose trigger stays high for `persist_i` consecutive cycles moves up exactly one level, and counting then restarts. A `persist_i` of 0 behaves as 1. Level 3 is the top level.
- R5: At level 0 a thread's decode weight is its priority. At level 1 the weight is 1, or 0 if the priority is 0. At levels 2 and 3 the weight is 0.
- R6: At levels 2 and 3, `dec_inhibit_o` is high for the thread and the thread gets no grant. A slot the schedule gives it goes to the other thread instead.
- R7: `flush_req_o` is a pulse lasting exactly one cycle, in the first cycle of level 3. While at level 3, decode stays inhibited.
- R8: When its trigger is low, a thread at level 1 returns to level 0 on the next edge. A thread at level 2 or 3 returns to level 0 only when its trigger is low and its `cong_clear_i` bit is high.
- R9: The two threads are never inhibited at once. A step to level 2 is held back while the other thread is at level 2 or above. When both threads are ready to step from level 1 to level 2 in the same cycle, only the thread whose trigger rose more recently steps; if both triggers rose in the same cycle, thread 1 steps.
- R10: At most one thread is granted in each cycle. Thread 0's share of a frame is floor(16*w0/(w0+w1)) and thread 1 gets the rest. The share is fixed at each frame boundary from the weights in the last cycle of the previous frame. The slots are spread through the frame by an accumulator. If both weights are 0, no thread is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l2_miss_i | input | 2 | Per-thread L2 load-miss pulse |
| tlb_miss_i | input | 2 | Per-thread TLB-miss pulse |
| l2_fill_i | input | 2 | Per-thread L2 fill pulse |
| tlb_fill_i | input | 2 | Per-thread TLB fill pulse |
| rob_occ_i | input | 2*ROB_W | Reorder-buffer occupancy; thread 0 in the low bits |
| pri_i | input | 2*PRI_W | Software priority; thread 0 in the low bits |
| cong_clear_i | input | 2 | Per-thread congestion-cleared condition |
| miss_thresh_i | input | MISS_W | Outstanding-miss threshold |
| rob_limit_i | input | ROB_W | Occupancy limit |
| persist_i | input | PER_W | Cycles a trigger must persist before a step up |
| dec_grant_o | output | 2 | Decode grant for this cycle, at most one bit set |
| dec_inhibit_o | output | 2 | Per-thread decode block |
| flush_req_o | output | 2 | Per-thread single-cycle flush request |

## Verification
Some rules are checked by assertions on every cycle: grants are one-hot or zero, a blocked thread is never granted, both threads are never blocked together, a flush pulse lasts one cycle and follows a blocked cycle, and a thread enters or leaves the blocked state only under the right trigger and clear conditions. Other behaviour can only be shown by the bench's scenarios. These cover the exact escalation timing for a given persistence, saturation of the miss count, the tie-break between threads that are ready together, the proportional frame shares, and the reassignment of a blocked thread's slots. The bench checks them against a cycle model built from the requirements.

// File: rtl/smt_thr_pkg.sv
package smt_thr_pkg;
  localparam int NTHR = 2;

  typedef enum logic [1:0] {
    LV_NORM  = 2'd0,
    LV_LOW   = 2'd1,
    LV_INH   = 2'd2,
    LV_FLUSH = 2'd3
  } lvl_e;

  function automatic logic lvl_blocks(input lvl_e l);
    return (l == LV_INH) || (l == LV_FLUSH);
  endfunction

  function automatic lvl_e lvl_step(input lvl_e l);
    case (l)
      LV_NORM: return LV_LOW;
      LV_LOW:  return LV_INH;
      default: return LV_FLUSH;
    endcase
  endfunction
endpackage

// File: rtl/smt_thr_miss_ctr.sv
module smt_thr_miss_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         l2_miss,
  input  logic         tlb_miss,
  input  logic         l2_fill,
  input  logic         tlb_fill,
  input  logic [W-1:0] thresh,
  output logic         over_o
);
  localparam int MAXV = (1 << W) - 1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         upd_en;
  int           sum_i;

  // Net change of the outstanding count in this cycle, clamped at both ends (R2)
  always_comb begin
    upd_en = l2_miss | tlb_miss | l2_fill | tlb_fill;
    sum_i  = int'(cnt_q) + int'(l2_miss) + int'(tlb_miss)
           - int'(l2_fill) - int'(tlb_fill);
    if (sum_i < 0)         cnt_d = '0;
    else if (sum_i > MAXV) cnt_d = W'(MAXV);
    else                   cnt_d = W'(sum_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_d;
  end

  assign over_o = (cnt_q >= thresh);
endmodule

// File: rtl/smt_thr_escalate.sv
module smt_thr_escalate
  import smt_thr_pkg::*;
#(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTHR-1:0]  trig,
  input  logic [NTHR-1:0]  clear,
  input  logic [PER_W-1:0] persist,
  output logic [2*NTHR-1:0] lvl_flat_o,
  output logic [NTHR-1:0]  flush_o
);
  lvl_e             lvl_q [NTHR];
  lvl_e             lvl_d [NTHR];
  logic [PER_W-1:0] pc_q  [NTHR];
  logic [PER_W-1:0] pc_d  [NTHR];
  logic [NTHR-1:0]  trig_q, rise, ready, to_inh, block;
  logic [NTHR-1:0]  flush_q, flush_d;
  logic             later_q, later_d;
  logic [PER_W-1:0] pm1;

  // A persistence of 0 acts as 1 (R4)
  assign pm1  = (persist == '0) ? '0 : persist - 1'b1;
  assign rise = trig & ~trig_q;

  // The thread whose trigger rose most recently; thread 1 on a tie (R9)
  always_comb begin
    later_d = later_q;
    if (&rise)        later_d = 1'b1;
    else if (rise[0]) later_d = 1'b0;
    else if (rise[1]) later_d = 1'b1;
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      ready[t]  = trig[t] && (lvl_q[t] != LV_FLUSH) && (pc_q[t] >= pm1);
      to_inh[t] = ready[t] && (lvl_q[t] == LV_LOW);
    end
    for (int t = 0; t < NTHR; t++) begin
      block[t] = to_inh[t] &&
                 (lvl_blocks(lvl_q[1-t]) || (to_inh[1-t] && (later_q != 1'(t))));
    end
    for (int t = 0; t < NTHR; t++) begin
      lvl_d[t] = lvl_q[t];
      pc_d[t]  = pc_q[t];
      if (!trig[t]) begin
        pc_d[t] = '0;
        if ((lvl_q[t] == LV_LOW) || (lvl_blocks(lvl_q[t]) && clear[t]))
          lvl_d[t] = LV_NORM;                       // R8
      end else if (ready[t] && !block[t]) begin
        lvl_d[t] = lvl_step(lvl_q[t]);              // R4
        pc_d[t]  = '0;
      end else if (!ready[t] && (lvl_q[t] != LV_FLUSH)) begin
        pc_d[t]  = pc_q[t] + 1'b1;
      end
      flush_d[t] = (lvl_d[t] == LV_FLUSH) && (lvl_q[t] != LV_FLUSH);  // R7
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        lvl_q[t] <= LV_NORM;
        pc_q[t]  <= '0;
      end
      trig_q  <= '0;
      flush_q <= '0;
      later_q <= 1'b0;
    end else begin
      for (int t = 0; t < NTHR; t++) begin
        lvl_q[t] <= lvl_d[t];
        pc_q[t]  <= pc_d[t];
      end
      trig_q  <= trig;
      flush_q <= flush_d;
      later_q <= later_d;
    end
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++) lvl_flat_o[2*t +: 2] = lvl_q[t];
  end
  assign flush_o = flush_q;
endmodule

// File: rtl/smt_thr_dshare.sv
module smt_thr_dshare
  import smt_thr_pkg::*;
#(
  parameter int FRAME = 16,
  parameter int PRI_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR*PRI_W-1:0] pri,
  input  logic [2*NTHR-1:0]    lvl_flat,
  input  logic [NTHR-1:0]      inh,
  output logic [NTHR-1:0]      grant_o
);
  localparam int SLOT_W = $clog2(FRAME);
  localparam int SH_W   = $clog2(FRAME + 1);
  localparam int ACC_W  = $clog2(FRAME) + 2;

  logic [PRI_W-1:0]  wgt [NTHR];
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SH_W-1:0]   s0_q, s0_new;
  logic              val_q, val_new;
  logic [ACC_W-1:0]  acc_q, acc_d, acc_sum;
  logic              pick0, frame_end;
  int                num_i, den_i;

  // Effective weight after throttling (R5)
  for (genvar t = 0; t < NTHR; t++) begin : g_wgt
    logic [PRI_W-1:0] p;
    assign p = pri[t*PRI_W +: PRI_W];
    always_comb begin
      case (lvl_e'(lvl_flat[2*t +: 2]))
        LV_NORM: wgt[t] = p;
        LV_LOW:  wgt[t] = (p != '0) ? PRI_W'(1) : '0;
        default: wgt[t] = '0;
      endcase
    end
  end

  // Thread 0 share of the next frame (R10)
  always_comb begin
    num_i   = FRAME * int'(wgt[0]);
    den_i   = int'(wgt[0]) + int'(wgt[1]);
    val_new = (den_i != 0);
    s0_new  = val_new ? SH_W'(num_i / den_i) : '0;
  end

  assign frame_end = (slot_q == SLOT_W'(FRAME - 1));
  assign acc_sum   = acc_q + ACC_W'(s0_q);
  assign pick0     = (acc_sum >= ACC_W'(FRAME));

  always_comb begin
    if (frame_end) begin
      slot_d = '0;
      acc_d  = '0;
    end else begin
      slot_d = slot_q + 1'b1;
      acc_d  = pick0 ? acc_sum - ACC_W'(FRAME) : acc_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      acc_q  <= '0;
      s0_q   <= '0;
      val_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      acc_q  <= acc_d;
      if (frame_end) begin
        s0_q  <= s0_new;
        val_q <= val_new;
      end
    end
  end

  // A slot scheduled for a blocked thread goes to the other one (R6)
  always_comb begin
    grant_o = '0;
    if (val_q) begin
      if (pick0) grant_o = inh[0] ? 2'b10 : 2'b01;
      else       grant_o = inh[1] ? 2'b01 : 2'b10;
    end
  end
endmodule

// File: rtl/smt_throttle_ctrl.sv
module smt_throttle_ctrl
  import smt_thr_pkg::*;
#(
  parameter int MISS_W = 5,
  parameter int ROB_W  = 6,
  parameter int PRI_W  = 3,
  parameter int PER_W  = 4,
  parameter int FRAME  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          l2_miss_i,
  input  logic [1:0]          tlb_miss_i,
  input  logic [1:0]          l2_fill_i,
  input  logic [1:0]          tlb_fill_i,
  input  logic [2*ROB_W-1:0]  rob_occ_i,
  input  logic [2*PRI_W-1:0]  pri_i,
  input  logic [1:0]          cong_clear_i,
  input  logic [MISS_W-1:0]   miss_thresh_i,
  input  logic [ROB_W-1:0]    rob_limit_i,
  input  logic [PER_W-1:0]    persist_i,
  output logic [1:0]          dec_grant_o,
  output logic [1:0]          dec_inhibit_o,
  output logic [1:0]          flush_req_o
);
  logic [NTHR-1:0]   miss_over, thr_trig, inh;
  logic [2*NTHR-1:0] lvl_flat;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    smt_thr_miss_ctr #(.W(MISS_W)) u_miss (
      .clk      (clk),
      .rst_n    (rst_n),
      .l2_miss  (l2_miss_i[t]),
      .tlb_miss (tlb_miss_i[t]),
      .l2_fill  (l2_fill_i[t]),
      .tlb_fill (tlb_fill_i[t]),
      .thresh   (miss_thresh_i),
      .over_o   (miss_over[t])
    );
    // Either congestion sign triggers the thread (R2, R3)
    assign thr_trig[t] = miss_over[t] | (rob_occ_i[t*ROB_W +: ROB_W] >= rob_limit_i);
    assign inh[t]      = lvl_blocks(lvl_e'(lvl_flat[2*t +: 2]));
  end

  smt_thr_escalate #(.PER_W(PER_W)) u_esc (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (thr_trig),
    .clear      (cong_clear_i),
    .persist    (persist_i),
    .lvl_flat_o (lvl_flat),
    .flush_o    (flush_req_o)
  );

  smt_thr_dshare #(.FRAME(FRAME), .PRI_W(PRI_W)) u_share (
    .clk      (clk),
    .rst_n    (rst_n),
    .pri      (pri_i),
    .lvl_flat (lvl_flat),
    .inh      (inh),
    .grant_o  (dec_grant_o)
  );

  assign dec_inhibit_o = inh;
endmodule

// File: rtl/smt_throttle_ctrl_chk.sv
module smt_throttle_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] grant,
  input logic [1:0] inh,
  input logic [1:0] flush,
  input logic [1:0] trig,
  input logic [1:0] clr
);
  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_no_grant_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & inh) == 2'b00);
  p_never_both_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(inh[0] && inh[1]));

  for (genvar t = 0; t < 2; t++) begin : g_t
    p_flush_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush[t] |=> !flush[t]);
    p_flush_holds_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush[t] |-> (inh[t] && $past(inh[t])));
    p_block_needs_trigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inh[t]) |-> $past(trig[t]));
    p_unblock_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inh[t]) |-> ($past(!trig[t]) && $past(clr[t])));
  end
endmodule

bind smt_throttle_ctrl smt_throttle_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .grant (dec_grant_o),
  .inh   (dec_inhibit_o),
  .flush (flush_req_o),
  .trig  (thr_trig),
  .clr   (cong_clear_i)
);

// File: tb/sim_smt_throttle_ctrl.sv
module sim_smt_throttle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MISS_W = 5, ROB_W = 6, PRI_W = 3, PER_W = 4, FRAME = 16;
  localparam int MAXC = (1 << MISS_W) - 1;

  logic clk, rst_n;
  logic [1:0] l2m, tlbm, l2f, tlbf, cclr;
  logic [ROB_W-1:0] rob0, rob1, rlim;
  logic [PRI_W-1:0] pr0, pr1;
  logic [MISS_W-1:0] mthr;
  logic [PER_W-1:0] pers;
  logic [1:0] grant, inh, flush;

  int checks = 0, errors = 0;
  bit done = 0;

  smt_throttle_ctrl #(.MISS_W(MISS_W), .ROB_W(ROB_W), .PRI_W(PRI_W),
                      .PER_W(PER_W), .FRAME(FRAME)) u0 (
    .clk(clk), .rst_n(rst_n), .l2_miss_i(l2m), .tlb_miss_i(tlbm),
    .l2_fill_i(l2f), .tlb_fill_i(tlbf), .rob_occ_i({rob1, rob0}),
    .pri_i({pr1, pr0}), .cong_clear_i(cclr), .miss_thresh_i(mthr),
    .rob_limit_i(rlim), .persist_i(pers), .dec_grant_o(grant),
    .dec_inhibit_o(inh), .flush_req_o(flush));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Cycle model built from the requirements
  int mc[2], ml[2], mp[2], mtq[2], mfl[2];
  int mlat, mslot, macc, ms0, mval;

  function automatic int robv(int t);
    return (t == 0) ? int'(rob0) : int'(rob1);
  endfunction
  function automatic int priv(int t);
    return (t == 0) ? int'(pr0) : int'(pr1);
  endfunction
  function automatic int trg(int t);
    return ((mc[t] >= int'(mthr)) || (robv(t) >= int'(rlim))) ? 1 : 0;
  endfunction
  function automatic int wgt(int t);
    if (ml[t] == 0) return priv(t);
    if (ml[t] == 1) return (priv(t) != 0) ? 1 : 0;
    return 0;
  endfunction
  function automatic logic [1:0] exp_grant();
    int g;
    if (mval == 0) return 2'b00;
    g = (macc + ms0 >= FRAME) ? 0 : 1;
    if (ml[g] >= 2) g = 1 - g;
    return (g == 0) ? 2'b01 : 2'b10;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin mc[t] = 0; ml[t] = 0; mp[t] = 0; mtq[t] = 0; mfl[t] = 0; end
      mlat = 0; mslot = 0; macc = 0; ms0 = 0; mval = 0;
    end else begin
      int tr[2], rdy[2], ti[2], blk[2], nl[2], np[2], nc[2], rs[2], pm1, w0, w1, p0;
      pm1 = (pers == 0) ? 0 : int'(pers) - 1;
      for (int t = 0; t < 2; t++) begin
        tr[t]  = trg(t);
        rs[t]  = (tr[t] == 1 && mtq[t] == 0) ? 1 : 0;
        rdy[t] = (tr[t] == 1 && ml[t] != 3 && mp[t] >= pm1) ? 1 : 0;
        ti[t]  = (rdy[t] == 1 && ml[t] == 1) ? 1 : 0;
        nc[t]  = mc[t] + int'(l2m[t]) + int'(tlbm[t]) - int'(l2f[t]) - int'(tlbf[t]);
        if (nc[t] < 0) nc[t] = 0;
        if (nc[t] > MAXC) nc[t] = MAXC;
      end
      for (int t = 0; t < 2; t++)
        blk[t] = (ti[t] == 1 && (ml[1-t] >= 2 || (ti[1-t] == 1 && mlat != t))) ? 1 : 0;
      for (int t = 0; t < 2; t++) begin
        nl[t] = ml[t]; np[t] = mp[t];
        if (tr[t] == 0) begin
          np[t] = 0;
          if (ml[t] == 1 || (ml[t] >= 2 && cclr[t])) nl[t] = 0;
        end else if (rdy[t] == 1 && blk[t] == 0) begin
          nl[t] = ml[t] + 1; np[t] = 0;
        end else if (rdy[t] == 0 && ml[t] != 3) np[t] = mp[t] + 1;
      end
      p0 = (mval != 0 && macc + ms0 >= FRAME) ? 1 : 0;
      w0 = wgt(0); w1 = wgt(1);
      if (mslot == FRAME - 1) begin
        mslot = 0; macc = 0;
        mval = (w0 + w1 != 0) ? 1 : 0;
        ms0 = (w0 + w1 != 0) ? (FRAME * w0) / (w0 + w1) : 0;
      end else begin
        mslot++;
        macc = (macc + ms0 >= FRAME) ? macc + ms0 - FRAME : macc + ms0;
      end
      if (p0 == 2) mslot = mslot;
      if (rs[0] == 1 && rs[1] == 1) mlat = 1;
      else if (rs[0] == 1) mlat = 0;
      else if (rs[1] == 1) mlat = 1;
      for (int t = 0; t < 2; t++) begin
        mfl[t] = (nl[t] == 3 && ml[t] != 3) ? 1 : 0;
        ml[t] = nl[t]; mp[t] = np[t]; mc[t] = nc[t]; mtq[t] = tr[t];
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model; the tag names the scenario requirement
  task automatic cmp(input string tag);
    logic [1:0] ei, ef;
    ei = {ml[1] >= 2, ml[0] >= 2};
    ef = {mfl[1] != 0, mfl[0] != 0};
    chk({tag, "/R10"}, "grant", int'(grant), int'(exp_grant()));
    chk({tag, "/R6"}, "inhibit", int'(inh), int'(ei));
    chk({tag, "/R7"}, "flush", int'(flush), int'(ef));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag);
      l2m = 0; tlbm = 0; l2f = 0; tlbf = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g0, g1;
    void'($urandom(32'h5A17));
    rst_n = 0; l2m = 0; tlbm = 0; l2f = 0; tlbf = 0; cclr = 0;
    rob0 = 0; rob1 = 0; rlim = 20; pr0 = 3; pr1 = 5; mthr = 3; pers = 3;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    chk("R1", "grant in reset", int'(grant), 0);
    chk("R1", "inhibit in reset", int'(inh), 0);
    chk("R1", "flush in reset", int'(flush), 0);
    rst_n = 1;
    chk("R1", "grant at release", int'(grant), 0);
    g0 = 0; g1 = 0;
    for (int i = 1; i < 80; i++) begin
      @(negedge clk);
      cmp("R1");
      if (i < 16) chk("R1", "grant in first frame", int'(grant), 0);
      else begin g0 += int'(grant[0]); g1 += int'(grant[1]); end
    end
    // R10: weights 3 and 5 give floor(48/8)=6 slots of 16 to thread 0, over 4 frames
    chk("R10", "thread0 grants in 4 frames", g0, 24);
    chk("R10", "thread1 grants in 4 frames", g1, 40);

    // R4/R6/R7: occupancy trigger on thread 0, persistence 3
    rob0 = 20;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      cmp("R4");
      if (i == 5) chk("R4", "not yet blocked after 5 cycles", int'(inh[0]), 0);
      if (i == 6) chk("R4", "blocked after 6 cycles", int'(inh[0]), 1);
      if (i == 9) chk("R7", "flush pulse at level 3 entry", int'(flush[0]), 1);
      if (i == 10) chk("R7", "flush pulse ends", int'(flush[0]), 0);
      if (i == 10) chk("R7", "still blocked at level 3", int'(inh[0]), 1);
    end
    run(20, "R6");
    // R8: trigger gone but no clear: stays blocked; then clear releases it
    rob0 = 0;
    run(5, "R8");
    chk("R8", "held without clear", int'(inh[0]), 1);
    cclr = 2'b01;
    @(negedge clk); cmp("R8");
    chk("R8", "released with clear", int'(inh[0]), 0);
    cclr = 0;
    run(20, "R5");

    // R3: occupancy at limit minus 1 never escalates
    rob1 = 19; pers = 1;
    run(10, "R3");
    chk("R3", "below limit stays unblocked", int'(inh[1]), 0);
    rob1 = 20;
    run(3, "R3");
    chk("R3", "at limit blocks", int'(inh[1]), 1);
    rob1 = 0; cclr = 2'b11;
    run(3, "R3");
    cclr = 0;

    // R2: miss count reaching the threshold of 3 triggers; fills drain it
    pers = 2;
    l2m = 2'b10; tlbm = 2'b10; run(1, "R2");
    l2m = 2'b10; run(6, "R2");
    l2f = 2'b10; tlbf = 2'b10; run(1, "R2");
    l2f = 2'b10; tlbf = 2'b10; run(1, "R2");
    l2f = 2'b10; run(4, "R2");
    cclr = 2'b11; run(4, "R2");
    cclr = 0;

    // R9: both triggers rise together; thread 1 steps to level 2, thread 0 held
    pers = 1;
    rob0 = 30; rob1 = 30;
    run(2, "R9");
    chk("R9", "tie blocks thread 1 only", int'(inh), 2);
    run(6, "R9");
    chk("R9", "thread 0 still unblocked", int'(inh[0]), 0);
    rob1 = 0; cclr = 2'b10;
    run(3, "R9");
    chk("R9", "thread 0 blocked once thread 1 leaves", int'(inh[0]), 1);
    rob0 = 0; cclr = 2'b11; run(3, "R9"); cclr = 0;

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      l2m  = 2'($urandom_range(0, 3)) & {$urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0};
      tlbm = 2'($urandom_range(0, 3)) & {$urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0};
      l2f  = 2'($urandom_range(0, 3)) & {$urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0};
      tlbf = 2'($urandom_range(0, 3)) & {$urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0};
      cclr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) rob0 = ROB_W'($urandom_range(0, 40));
      if ($urandom_range(0, 15) == 0) rob1 = ROB_W'($urandom_range(0, 40));
      if ($urandom_range(0, 63) == 0) begin pr0 = PRI_W'($urandom); pr1 = PRI_W'($urandom); end
      if ($urandom_range(0, 255) == 0) begin
        pers = PER_W'($urandom_range(0, 5));
        mthr = MISS_W'($urandom_range(1, 8));
        rlim = ROB_W'($urandom_range(15, 35));
      end
      @(negedge clk);
      cmp("RND");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule